// File: doc/BRIEF.md
# Paged CSR Window Address Decoder

This block is a register-access slave behind a 4 KB memory-mapped window. It maps every bus offset onto a 16-bit internal register address. The lower three quarters of the window (offsets 0x000 to 0xBFF) map one to one onto the same internal offset. The top quarter (0xC00 to 0xFFF) is an aperture that is steered by a 6-bit page number held in a control register. The page number supplies the upper six address bits, and the low ten bus bits supply the rest. This lets a 4 KB window reach a 64 KB register space.

Each request is qualified before it touches storage. The size must be 1, 2 or 4 bytes, the address must be a multiple of that size, and exactly one of read or write must be set. A request that passes drives byte-lane enables into a small internal register store. A request that fails is answered with an error flag and has no side effects. Every request gets a response on the following cycle.

By default the implemented storage is the control register at internal offset 0x080, sixteen words at 0x000–0x03F and eight words at 0x4000–0x401F. Each of these locations is a parameter.

Top module: `paged_csr_window`

## Requirements
- R1: A valid access to a bus offset below 0xC00 reaches the internal register at exactly that offset.
- R2: A valid access to a bus offset in 0xC00–0xFFF reaches internal address {page, offset[9:0]}, where page is the 6-bit page field. This path reaches storage that is separate from the direct region whenever the page is 3 or above.
- R3: The page field is bits 18:13 of a 32-bit control register at internal offset 0x080. All 32 bits of that register are plain read/write storage and reset to 0. A byte write to it changes only the addressed lane, so the page can be changed while every other bit is kept.
- R4: req_size_i is a byte count. Only the values 1, 2 and 4 are accepted. Any other size, or a request with read and write both set, is rejected.
- R5: A request whose address is not a multiple of its size is rejected (for example, size 2 at an odd address, or size 4 with addr[1:0] not equal to 0).
- R6: A rejected request returns read data 0 and raises rsp_err_o for exactly the one response cycle. It changes no register, and that includes the page field.
- R7: Write data is right-aligned in req_wdata_i. A 1- or 2-byte write updates only the addressed byte lanes and ignores the unused upper data bits.
- R8: A 1- or 2-byte read returns the addressed bytes right-aligned in rsp_rdata_o, with the upper bits set to zero.
- R9: With page values 0–2 the aperture aliases the direct region. Either path reaches the same storage, and this includes the control register.
- R10: An internal address with no implemented register reads as 0 and ignores writes, and neither case raises an error. Implemented storage is the control register, internal 0x000–0x03F and internal 0x4000–0x401F.
- R11: rsp_valid_o is high in exactly the cycle after a request and low otherwise. A page-field write is in effect for a request issued in the very next cycle.
- R12: While rst_ni is low, all storage clears and rsp_valid_o, rsp_err_o and rsp_rdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | 12 | Byte offset within the 4 KB window |
| req_wdata_i | input | 32 | Write data, right-aligned |
| req_size_i | input | 3 | Access size in bytes (1, 2, 4 legal) |
| req_rd_i | input | 1 | Read request |
| req_wr_i | input | 1 | Write request |
| rsp_rdata_o | output | 32 | Read data, right-aligned, zero-extended |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_err_o | output | 1 | Previous request was rejected |

## Verification
Two things can meet in consecutive cycles: a write that moves the page field, and the translation of an aperture access that uses the new page. The bench drives a control-register write and, with no idle cycle in between, a read through the aperture. It then checks that the read returns the word stored on the new page and not on the old one. A second such pairing places a rejected write aimed at the control register next to an accepted read of it. The bench judges this by confirming that the page and all other control bits are unchanged.

// File: rtl/paged_csr_pkg.sv
package paged_csr_pkg;
  localparam int unsigned BUS_AW   = 12;
  localparam int unsigned INT_AW   = 16;
  localparam int unsigned DW       = 32;
  localparam int unsigned NB       = DW / 8;
  localparam int unsigned PAGE_W   = 6;
  localparam int unsigned PG_OFS_W = INT_AW - PAGE_W;
  localparam int unsigned WA_W     = INT_AW - 2;
  localparam logic [BUS_AW-1:0] APERTURE_BASE = 12'hC00;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd1,
    SZ_HALF = 3'd2,
    SZ_WORD = 3'd4
  } acc_size_e;

  function automatic logic size_legal(logic [2:0] s);
    return (s == SZ_BYTE) || (s == SZ_HALF) || (s == SZ_WORD);
  endfunction

  function automatic logic addr_aligned(logic [2:0] s, logic [1:0] a);
    case (s)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return ~a[0];
      SZ_WORD: return a == 2'b00;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/paged_csr_xlate.sv
module paged_csr_xlate
  import paged_csr_pkg::*;
(
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [2:0]        size_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [INT_AW-1:0] int_addr_o,
  output logic              ok_o,
  output logic [NB-1:0]     be_o
);
  logic in_aperture;

  assign in_aperture = bus_addr_i >= APERTURE_BASE;

  always_comb begin
    if (in_aperture) int_addr_o = {page_i, bus_addr_i[PG_OFS_W-1:0]};
    else             int_addr_o = {{(INT_AW-BUS_AW){1'b0}}, bus_addr_i};
  end

  assign ok_o = (rd_i ^ wr_i) && size_legal(size_i) && addr_aligned(size_i, bus_addr_i[1:0]);

  always_comb begin
    case (size_i)
      SZ_BYTE: be_o = 4'b0001 << bus_addr_i[1:0];
      SZ_HALF: be_o = 4'b0011 << bus_addr_i[1:0];
      SZ_WORD: be_o = 4'b1111;
      default: be_o = 4'b0000;
    endcase
  end
endmodule

// File: rtl/paged_csr_bank.sv
module paged_csr_bank
  import paged_csr_pkg::*;
#(
  parameter logic [INT_AW-1:0] BASE  = 16'h0000,
  parameter int unsigned       WORDS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WA_W-1:0] waddr_i,
  input  logic            we_i,
  input  logic [NB-1:0]   be_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            hit_o,
  output logic [DW-1:0]   rdata_o
);
  localparam logic [WA_W-1:0] BASE_W = BASE[INT_AW-1:2];

  logic [DW-1:0] mem_q [WORDS];
  logic [WORDS-1:0] sel;

  for (genvar w = 0; w < WORDS; w++) begin : g_sel
    assign sel[w] = waddr_i == (BASE_W + WA_W'(w));
  end

  assign hit_o = |sel;

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < WORDS; w++)
      if (sel[w]) rdata_o = rdata_o | mem_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (we_i) begin
      for (int w = 0; w < WORDS; w++)
        for (int b = 0; b < NB; b++)
          if (sel[w] && be_i[b]) mem_q[w][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end
endmodule

// File: rtl/paged_csr_window.sv
module paged_csr_window
  import paged_csr_pkg::*;
#(
  parameter logic [INT_AW-1:0] CTRL_OFF = 16'h0080,
  parameter int unsigned       PAGE_LSB = 13,
  parameter logic [INT_AW-1:0] LO_BASE  = 16'h0000,
  parameter int unsigned       LO_WORDS = 16,
  parameter logic [INT_AW-1:0] HI_BASE  = 16'h4000,
  parameter int unsigned       HI_WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [2:0]        req_size_i,
  input  logic              req_rd_i,
  input  logic              req_wr_i,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o
);
  logic [DW-1:0]     ctrl_q;
  logic [PAGE_W-1:0] page;
  logic [INT_AW-1:0] int_addr;
  logic              acc_ok, do_wr, do_rd, ctrl_hit;
  logic [NB-1:0]     be;
  logic [DW-1:0]     wdata_al, rd_word, rd_sh, rd_fmt;
  logic              lo_hit, hi_hit;
  logic [DW-1:0]     lo_rdata, hi_rdata;
  logic [4:0]        lane_sh;

  assign page = ctrl_q[PAGE_LSB +: PAGE_W];

  paged_csr_xlate u_xlate (
    .bus_addr_i (req_addr_i),
    .size_i     (req_size_i),
    .rd_i       (req_rd_i),
    .wr_i       (req_wr_i),
    .page_i     (page),
    .int_addr_o (int_addr),
    .ok_o       (acc_ok),
    .be_o       (be)
  );

  assign do_wr    = req_wr_i & acc_ok;
  assign do_rd    = req_rd_i & acc_ok;
  assign ctrl_hit = int_addr[INT_AW-1:2] == CTRL_OFF[INT_AW-1:2];
  assign lane_sh  = {req_addr_i[1:0], 3'b000};
  assign wdata_al = req_wdata_i << lane_sh;

  // control register: plain byte-lane storage, page field is a slice of it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (do_wr && ctrl_hit) begin
      for (int b = 0; b < NB; b++)
        if (be[b]) ctrl_q[8*b +: 8] <= wdata_al[8*b +: 8];
    end
  end

  paged_csr_bank #(.BASE(LO_BASE), .WORDS(LO_WORDS)) u_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .waddr_i (int_addr[INT_AW-1:2]),
    .we_i    (do_wr & ~ctrl_hit),
    .be_i    (be),
    .wdata_i (wdata_al),
    .hit_o   (lo_hit),
    .rdata_o (lo_rdata)
  );

  paged_csr_bank #(.BASE(HI_BASE), .WORDS(HI_WORDS)) u_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .waddr_i (int_addr[INT_AW-1:2]),
    .we_i    (do_wr & ~ctrl_hit),
    .be_i    (be),
    .wdata_i (wdata_al),
    .hit_o   (hi_hit),
    .rdata_o (hi_rdata)
  );

  always_comb begin
    if (ctrl_hit)    rd_word = ctrl_q;
    else if (lo_hit) rd_word = lo_rdata;
    else if (hi_hit) rd_word = hi_rdata;
    else             rd_word = '0;
  end

  assign rd_sh = rd_word >> lane_sh;

  always_comb begin
    case (req_size_i)
      SZ_BYTE: rd_fmt = {24'h0, rd_sh[7:0]};
      SZ_HALF: rd_fmt = {16'h0, rd_sh[15:0]};
      default: rd_fmt = rd_sh;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_rd_i | req_wr_i;
      rsp_err_o   <= (req_rd_i | req_wr_i) & ~acc_ok;
      rsp_rdata_o <= do_rd ? rd_fmt : '0;
    end
  end
endmodule

// File: rtl/paged_csr_window_chk.sv
module paged_csr_window_chk
  import paged_csr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_AW-1:0] req_addr_i,
  input logic [2:0]        req_size_i,
  input logic              req_rd_i,
  input logic              req_wr_i,
  input logic [DW-1:0]     rsp_rdata_o,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [PAGE_W-1:0] page_i
);
  logic acc, misal, bad_size, bad;

  assign acc      = req_rd_i | req_wr_i;
  assign misal    = (req_size_i == 3'd2 && req_addr_i[0]) ||
                    (req_size_i == 3'd4 && req_addr_i[1:0] != 2'b00);
  assign bad_size = !(req_size_i == 3'd1 || req_size_i == 3'd2 || req_size_i == 3'd4);
  assign bad      = (req_rd_i && req_wr_i) || misal || bad_size;

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);
  // R6
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == '0));
  // R5
  misaligned_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && misal) |=> rsp_err_o);
  // R4
  bad_size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && bad_size) |=> rsp_err_o);
  // R6
  reject_keeps_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && bad) |=> $stable(page_i));
  // R10
  good_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !bad) |=> !rsp_err_o);
  // R8
  byte_zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rd_i && !req_wr_i && req_size_i == 3'd1) |=> rsp_rdata_o[31:8] == 24'h0);
endmodule

bind paged_csr_window paged_csr_window_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .req_rd_i    (req_rd_i),
  .req_wr_i    (req_wr_i),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .page_i      (page)
);

// File: tb/paged_csr_window_test.sv
module paged_csr_window_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  size = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] rdata;
  logic        valid, err;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  paged_csr_window uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_addr_i(addr), .req_wdata_i(wdata),
    .req_size_i(size), .req_rd_i(rd), .req_wr_i(wr),
    .rsp_rdata_o(rdata), .rsp_valid_o(valid), .rsp_err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit r, input bit w, input logic [11:0] a,
                       input logic [2:0] s, input logic [31:0] d);
    rd = r; wr = w; addr = a; size = s; wdata = d;
  endtask

  task automatic idle();
    rd = 1'b0; wr = 1'b0; addr = '0; size = '0; wdata = '0;
  endtask

  task automatic acc(input bit r, input bit w, input logic [11:0] a, input logic [2:0] s,
                     input logic [31:0] d, output logic [31:0] q, output logic e,
                     output logic v);
    @(negedge clk);
    drive(r, w, a, s, d);
    @(negedge clk);
    q = rdata; e = err; v = valid;
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] q; logic e, v;
    chk("R12 valid in reset", {31'h0, valid}, 32'h0);
    chk("R12 err in reset", {31'h0, err}, 32'h0);
    chk("R12 rdata in reset", rdata, 32'h0);
    @(negedge clk); rst_ni = 1'b1;
    acc(1, 0, 12'h080, 3'd4, 0, q, e, v);
    chk("R3 ctrl reset value", q, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] q; logic e, v;
    acc(0, 1, 12'h004, 3'd4, 32'hCAFEF00D, q, e, v);
    chk("R11 write response valid", {31'h0, v}, 32'h1);
    acc(1, 0, 12'h004, 3'd4, 0, q, e, v);
    chk("R1 direct readback", q, 32'hCAFEF00D);
    chk("R1 no error", {31'h0, e}, 32'h0);
  endtask

  task automatic t_paged();
    logic [31:0] q; logic e, v;
    acc(0, 1, 12'h080, 3'd4, 32'h0002_0005, q, e, v);  // page 16
    acc(1, 0, 12'h080, 3'd4, 0, q, e, v);
    chk("R3 ctrl readback", q, 32'h0002_0005);
    acc(0, 1, 12'hC08, 3'd4, 32'h1234_5678, q, e, v);
    acc(1, 0, 12'hC08, 3'd4, 0, q, e, v);
    chk("R2 paged readback", q, 32'h1234_5678);
    acc(0, 1, 12'h080, 3'd4, 32'h0000_0005, q, e, v);  // page 0
    acc(1, 0, 12'h008, 3'd4, 0, q, e, v);
    chk("R2 paged store separate from direct", q, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] q; logic e, v;
    acc(0, 1, 12'h008, 3'd4, 32'hA5A5_0001, q, e, v);
    acc(1, 0, 12'hC08, 3'd4, 0, q, e, v);
    chk("R9 aperture sees direct write", q, 32'hA5A5_0001);
    acc(0, 1, 12'hC0C, 3'd4, 32'h0BAD_CAFE, q, e, v);
    acc(1, 0, 12'h00C, 3'd4, 0, q, e, v);
    chk("R9 direct sees aperture write", q, 32'h0BAD_CAFE);
    acc(1, 0, 12'hC80, 3'd4, 0, q, e, v);
    chk("R9 ctrl via aperture", q, 32'h0000_0005);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    drive(0, 1, 12'h080, 3'd4, 32'h0002_0005);  // page 16
    @(negedge clk);
    chk("R11 page write response", {30'h0, valid, err}, 32'h2);
    drive(1, 0, 12'hC08, 3'd4, 0);
    @(negedge clk);
    chk("R11 next access uses new page", rdata, 32'h1234_5678);
    idle();
    @(negedge clk);
    chk("R11 no response when idle", {31'h0, valid}, 32'h0);
  endtask

  task automatic t_ctrl_byte();
    logic [31:0] q; logic e, v;
    acc(0, 1, 12'h081, 3'd1, 32'hFFFF_FF20, q, e, v);
    acc(1, 0, 12'h080, 3'd4, 0, q, e, v);
    chk("R3 byte write keeps other ctrl bits", q, 32'h0002_2005);
    acc(1, 0, 12'hC08, 3'd4, 0, q, e, v);  // page 17 -> 0x4408, unimplemented
    chk("R10 unimplemented paged read", q, 32'h0);
    chk("R10 unimplemented no error", {31'h0, e}, 32'h0);
  endtask

  task automatic t_subword();
    logic [31:0] q; logic e, v;
    acc(0, 1, 12'h010, 3'd4, 32'h1122_3344, q, e, v);
    acc(0, 1, 12'h012, 3'd1, 32'hFFFF_FFAB, q, e, v);
    acc(1, 0, 12'h010, 3'd4, 0, q, e, v);
    chk("R7 byte lane write", q, 32'h11AB_3344);
    acc(1, 0, 12'h012, 3'd2, 0, q, e, v);
    chk("R8 half read upper", q, 32'h0000_11AB);
    acc(1, 0, 12'h013, 3'd1, 0, q, e, v);
    chk("R8 byte read lane 3", q, 32'h0000_0011);
    acc(0, 1, 12'h010, 3'd2, 32'hFFFF_BEEF, q, e, v);
    acc(1, 0, 12'h010, 3'd4, 0, q, e, v);
    chk("R7 half write low lanes", q, 32'h11AB_BEEF);
  endtask

  task automatic t_reject();
    logic [31:0] q; logic e, v;
    acc(0, 1, 12'h010, 3'd3, 32'h0, q, e, v);
    chk("R4 size 3 error", {31'h0, e}, 32'h1);
    acc(1, 0, 12'h010, 3'd4, 0, q, e, v);
    chk("R6 rejected write no change", q, 32'h11AB_BEEF);
    acc(1, 0, 12'h012, 3'd4, 0, q, e, v);
    chk("R5 misaligned word read error", {31'h0, e}, 32'h1);
    chk("R6 rejected read returns zero", q, 32'h0);
    acc(0, 1, 12'h011, 3'd2, 32'h0, q, e, v);
    chk("R5 odd half write error", {31'h0, e}, 32'h1);
    acc(1, 1, 12'h010, 3'd4, 32'h0, q, e, v);
    chk("R4 read and write together error", {31'h0, e}, 32'h1);
    acc(1, 0, 12'h010, 3'd0, 0, q, e, v);
    chk("R4 size 0 error", {31'h0, e}, 32'h1);
    @(negedge clk);
    drive(0, 1, 12'h082, 3'd4, 32'h0);
    @(negedge clk);
    chk("R6 rejected ctrl write error", {31'h0, err}, 32'h1);
    drive(1, 0, 12'h080, 3'd4, 0);
    @(negedge clk);
    chk("R6 page kept after rejected write", rdata, 32'h0002_2005);
    chk("R6 error lasts one cycle", {31'h0, err}, 32'h0);
    idle();
  endtask

  task automatic t_unimpl();
    logic [31:0] q; logic e, v;
    acc(0, 1, 12'h100, 3'd4, 32'hDEAD_BEEF, q, e, v);
    chk("R10 unimplemented write no error", {31'h0, e}, 32'h0);
    acc(1, 0, 12'h100, 3'd4, 0, q, e, v);
    chk("R10 unimplemented reads zero", q, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_direct();
    t_paged();
    t_alias();
    t_back_to_back();
    t_ctrl_byte();
    t_subword();
    t_reject();
    t_unimpl();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule